// File: doc/BRIEF.md
# Low-Power Clock Source Selector

This block produces three clock-enable strobes inside a single fast clock domain: one for the module clock, and one for each of two clock outputs. In normal running the strobes come from a PLL-domain tick through a programmable slow-go divider. The module clock then equals the system clock, and its default rate is half the PLL tick rate. Clock output 1 tracks the module clock exactly. Clock output 2 runs at twice the system rate.

When software asks for low-power stop, the block waits for the current divider period to end. It then switches to one of two stop sources, chosen by a configuration bit:
- The PLL is kept running, and the module clock becomes half the PLL tick rate.
- The PLL is treated as off, and the module clock is taken from the crystal tick divided by 2, or by 256 when the divide-by-128 option is set.

A wake request returns the block to PLL timing at the next divider boundary. Each clock output has a 2-bit drive code. The disabled code removes both that output's strobe and its output enable. The other three codes, which differ only in pad strength, pass the strobe unchanged.

Top module: `lpc_clock_select`

## Requirements
- R1: While reset is asserted, and in the cycle after it, every strobe and every output enable is low. The block starts in running mode with its divider at zero.
- R2: In running mode with slow-go code c, `mod_clk_en` pulses for one cycle, once every 2<<c PLL ticks. The pulse appears in the cycle after the tick that completes the count, so code 0 gives half the PLL tick rate.
- R3: `clk1_en` is identical to `mod_clk_en` in every mode whenever drive code `drv1` is not 2'b11.
- R4: In running mode `clk2_en` pulses once every 1<<c PLL ticks, which is twice the module-clock rate. Every module-clock pulse coincides with a `clk2_en` pulse. `clk2_en` is never high in either stop mode.
- R5: A stop request takes effect only at the end of the current module-clock period, which is the tick that produces a `mod_clk_en` pulse. The stop variant is picked from `cfg_stop_pll_off` at that moment. The mode never changes between boundaries.
- R6: In stop with `cfg_stop_pll_off`=0, `mod_clk_en` pulses once every 2 PLL ticks, and crystal ticks have no effect.
- R7: In stop with `cfg_stop_pll_off`=1, `mod_clk_en` pulses once every 2 crystal ticks, or once every 256 crystal ticks when `cfg_div128`=1. PLL ticks have no effect.
- R8: After `wake`, the block returns to running mode at the next boundary of the current stop source. If `wake` and `stop_req` arrive in the same cycle, `wake` wins.
- R9: Drive code 2'b11 forces that output's strobe and enable low from the next cycle. Codes 2'b00, 2'b01 and 2'b10 set the enable high and pass the strobe.
- R10: The divider restarts from zero on every mode change. The first period in the new mode therefore has full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | fast clock for all logic |
| rst_n | input | 1 | active-low synchronous reset |
| pll_tick | input | 1 | one-cycle tick at the PLL rate |
| xtal_tick | input | 1 | one-cycle tick at the crystal rate |
| stop_req | input | 1 | request to enter low-power stop |
| wake | input | 1 | request to leave stop |
| cfg_stop_pll_off | input | 1 | 1: the PLL is treated as off during stop |
| cfg_div128 | input | 1 | extra divide by 128 on the crystal source during stop |
| cfg_slowgo | input | SG_W | slow-go divider code c |
| drv1 | input | 2 | drive code for output 1 (2'b11 = disabled) |
| drv2 | input | 2 | drive code for output 2 (2'b11 = disabled) |
| mod_clk_en | output | 1 | module clock enable strobe |
| clk1_en | output | 1 | output 1 enable strobe |
| clk2_en | output | 1 | output 2 enable strobe |
| clk1_oe | output | 1 | output 1 enable |
| clk2_oe | output | 1 | output 2 enable |

## Verification
A mode request and a divider boundary can land in the same cycle. So can a wake request and a fresh stop request. The bench arranges both. It issues a stop request partway through a slow-go period and confirms that the module strobe count and the source in use change only at the completing tick. It also raises wake and stop together and confirms that the output 2 strobes keep running. Strobes are counted over fixed tick windows, and each count is compared with the count implied by the divide ratio of the selected source.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
   typedef enum logic [1:0] {
      MODE_RUN       = 2'd0,
      MODE_STOP_PLL  = 2'd1,
      MODE_STOP_XTAL = 2'd2
   } lpc_mode_e;

   localparam logic [1:0] DRV_OFF = 2'b11;
endpackage

// File: rtl/lpc_mode_ctrl.sv
module lpc_mode_ctrl
   import lpc_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      boundary,
   input  logic      stop_req,
   input  logic      wake,
   input  logic      cfg_stop_pll_off,
   output lpc_mode_e mode_q,
   output logic      want_q
);
   logic want_nx;

   // wake has priority over a stop request in the same cycle
   always_comb begin
      if (wake)          want_nx = 1'b0;
      else if (stop_req) want_nx = 1'b1;
      else               want_nx = want_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         want_q <= 1'b0;
         mode_q <= MODE_RUN;
      end else begin
         want_q <= want_nx;
         if (boundary) begin
            if (!want_nx)
               mode_q <= MODE_RUN;
            else if (mode_q == MODE_RUN)
               mode_q <= cfg_stop_pll_off ? MODE_STOP_XTAL : MODE_STOP_PLL;
         end
      end
   end
endmodule

// File: rtl/lpc_divider.sv
module lpc_divider
   import lpc_pkg::*;
#(
   parameter int SG_W = 3,
   parameter int XDIV = 128
) (
   input  logic            clk,
   input  logic            rst_n,
   input  lpc_mode_e       mode,
   input  logic            pll_tick,
   input  logic            xtal_tick,
   input  logic [SG_W-1:0] sg_code,
   input  logic            cfg_div128,
   output logic            boundary,
   output logic            half_tick
);
   localparam int MAX_CODE = (1 << SG_W) - 1;
   localparam int RUN_SPAN = 2 << MAX_CODE;
   localparam int XT_SPAN  = 2 * XDIV;
   localparam int CNT_W    = $clog2(RUN_SPAN > XT_SPAN ? RUN_SPAN : XT_SPAN);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W:0]   one_ext, run_span, half_span, limit_ext, cnt_nx;
   logic [SG_W:0]    run_sh;
   logic             src_tick, at_lim;

   assign one_ext   = {{CNT_W{1'b0}}, 1'b1};
   assign run_sh    = {1'b0, sg_code} + 1'b1;
   assign run_span  = one_ext << run_sh;
   assign half_span = one_ext << sg_code;
   assign cnt_nx    = {1'b0, cnt_q} + 1'b1;

   always_comb begin
      unique case (mode)
         MODE_RUN:       limit_ext = run_span - 1'b1;
         MODE_STOP_XTAL: limit_ext = cfg_div128 ? (CNT_W+1)'(XT_SPAN - 1) : (CNT_W+1)'(1);
         default:        limit_ext = (CNT_W+1)'(1);
      endcase
   end

   assign src_tick  = (mode == MODE_STOP_XTAL) ? xtal_tick : pll_tick;
   assign at_lim    = {1'b0, cnt_q} >= limit_ext;
   assign boundary  = src_tick & at_lim;
   assign half_tick = (mode == MODE_RUN) && pll_tick
                      && ((cnt_nx & (half_span - 1'b1)) == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)        cnt_q <= '0;
      else if (boundary) cnt_q <= '0;
      else if (src_tick) cnt_q <= cnt_nx[CNT_W-1:0];
   end
endmodule

// File: rtl/lpc_out_gate.sv
module lpc_out_gate #(
   parameter bit REG_OUT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stb_in,
   input  logic en_in,
   output logic stb_out
);
   generate
      if (REG_OUT) begin : g_reg
         logic stb_q;
         always_ff @(posedge clk) begin
            if (!rst_n) stb_q <= 1'b0;
            else        stb_q <= stb_in & en_in;
         end
         assign stb_out = stb_q;
      end else begin : g_comb
         assign stb_out = stb_in & en_in & rst_n;
      end
   endgenerate
endmodule

// File: rtl/lpc_clock_select.sv
module lpc_clock_select
   import lpc_pkg::*;
#(
   parameter int SG_W    = 3,
   parameter int XDIV    = 128,
   parameter bit REG_OUT = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pll_tick,
   input  logic            xtal_tick,
   input  logic            stop_req,
   input  logic            wake,
   input  logic            cfg_stop_pll_off,
   input  logic            cfg_div128,
   input  logic [SG_W-1:0] cfg_slowgo,
   input  logic [1:0]      drv1,
   input  logic [1:0]      drv2,
   output logic            mod_clk_en,
   output logic            clk1_en,
   output logic            clk2_en,
   output logic            clk1_oe,
   output logic            clk2_oe
);
   generate
      if (SG_W < 1 || SG_W > 4) begin : g_bad_sgw
         $error("lpc_clock_select: SG_W must lie in 1..4");
      end
      if (XDIV < 1 || (XDIV & (XDIV - 1)) != 0) begin : g_bad_xdiv
         $error("lpc_clock_select: XDIV must be a power of two");
      end
   endgenerate

   lpc_mode_e mode_q;
   logic      want_q;
   logic      boundary, half_tick;
   logic      en1, en2;
   logic      oe1_q, oe2_q;

   assign en1 = (drv1 != DRV_OFF);
   assign en2 = (drv2 != DRV_OFF);

   lpc_mode_ctrl u_mode (
      .clk              (clk),
      .rst_n            (rst_n),
      .boundary         (boundary),
      .stop_req         (stop_req),
      .wake             (wake),
      .cfg_stop_pll_off (cfg_stop_pll_off),
      .mode_q           (mode_q),
      .want_q           (want_q)
   );

   lpc_divider #(.SG_W(SG_W), .XDIV(XDIV)) u_div (
      .clk        (clk),
      .rst_n      (rst_n),
      .mode       (mode_q),
      .pll_tick   (pll_tick),
      .xtal_tick  (xtal_tick),
      .sg_code    (cfg_slowgo),
      .cfg_div128 (cfg_div128),
      .boundary   (boundary),
      .half_tick  (half_tick)
   );

   lpc_out_gate #(.REG_OUT(REG_OUT)) u_gmod (
      .clk(clk), .rst_n(rst_n), .stb_in(boundary), .en_in(1'b1), .stb_out(mod_clk_en));
   lpc_out_gate #(.REG_OUT(REG_OUT)) u_g1 (
      .clk(clk), .rst_n(rst_n), .stb_in(boundary), .en_in(en1), .stb_out(clk1_en));
   lpc_out_gate #(.REG_OUT(REG_OUT)) u_g2 (
      .clk(clk), .rst_n(rst_n), .stb_in(half_tick), .en_in(en2), .stb_out(clk2_en));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe1_q <= 1'b0;
         oe2_q <= 1'b0;
      end else begin
         oe1_q <= en1;
         oe2_q <= en2;
      end
   end

   assign clk1_oe = oe1_q;
   assign clk2_oe = oe2_q;
endmodule

// File: rtl/lpc_clock_select_chk.sv
module lpc_clock_select_chk
   import lpc_pkg::*;
#(
   parameter bit REG_OUT = 1'b1
) (
   input logic      clk,
   input logic      rst_n,
   input logic      pll_tick,
   input logic      xtal_tick,
   input logic      wake,
   input logic [1:0] drv1,
   input logic [1:0] drv2,
   input logic      mod_clk_en,
   input logic      clk1_en,
   input logic      clk2_en,
   input logic      clk1_oe,
   input logic      clk2_oe,
   input lpc_mode_e mode_q,
   input logic      want_q
);
   generate
      if (REG_OUT) begin : g_props
         // R3
         out1_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clk1_en |-> mod_clk_en);
         // R9
         drv1_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (drv1 == DRV_OFF) |=> (!clk1_oe && !clk1_en));
         // R9
         drv2_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (drv2 == DRV_OFF) |=> (!clk2_oe && !clk2_en));
         // R4
         out2_quiet_in_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q != MODE_RUN) |=> !clk2_en);
         // R4
         mod_has_out2_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mod_clk_en && (drv2 != DRV_OFF) && $past(drv2 != DRV_OFF)
             && $past(mode_q == MODE_RUN)) |-> clk2_en);
         // R6
         stop_pll_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == MODE_STOP_PLL && !pll_tick) |=> !mod_clk_en);
         // R7
         stop_xtal_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q == MODE_STOP_XTAL && !xtal_tick) |=> !mod_clk_en);
         // R5
         mode_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q != $past(mode_q)) |-> mod_clk_en);
         // R8
         wake_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            wake |=> !want_q);
      end
   endgenerate
endmodule

bind lpc_clock_select lpc_clock_select_chk #(.REG_OUT(REG_OUT)) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pll_tick   (pll_tick),
   .xtal_tick  (xtal_tick),
   .wake       (wake),
   .drv1       (drv1),
   .drv2       (drv2),
   .mod_clk_en (mod_clk_en),
   .clk1_en    (clk1_en),
   .clk2_en    (clk2_en),
   .clk1_oe    (clk1_oe),
   .clk2_oe    (clk2_oe),
   .mode_q     (mode_q),
   .want_q     (want_q)
);

// File: tb/test_lpc_clock_select.sv
`timescale 1ns/1ps
module test_lpc_clock_select;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pll_tick = 1'b0, xtal_tick = 1'b0;
   logic       stop_req = 1'b0, wake = 1'b0;
   logic       cfg_stop_pll_off = 1'b0, cfg_div128 = 1'b0;
   logic [2:0] cfg_slowgo = '0;
   logic [1:0] drv1 = '0, drv2 = '0;
   logic       mod_clk_en, clk1_en, clk2_en, clk1_oe, clk2_oe;

   int checks = 0, errors = 0;
   int n_sim = 0, n_o1 = 0, n_o2 = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   lpc_clock_select i_lpc_clock_select (
      .clk(clk), .rst_n(rst_n), .pll_tick(pll_tick), .xtal_tick(xtal_tick),
      .stop_req(stop_req), .wake(wake), .cfg_stop_pll_off(cfg_stop_pll_off),
      .cfg_div128(cfg_div128), .cfg_slowgo(cfg_slowgo), .drv1(drv1), .drv2(drv2),
      .mod_clk_en(mod_clk_en), .clk1_en(clk1_en), .clk2_en(clk2_en),
      .clk1_oe(clk1_oe), .clk2_oe(clk2_oe));

   typedef struct packed {
      int code; int stop; int off; int d128; int d1; int d2;
      int npll; int nx; int esim; int eo2;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{0, 0, 0, 0, 0, 1,   8,   4, 4, 8},
      '{1, 0, 0, 0, 1, 2,  12,   0, 3, 6},
      '{2, 0, 0, 0, 3, 0,  16,   5, 2, 4},
      '{3, 0, 0, 0, 2, 3,  15,   0, 0, 1},
      '{2, 1, 0, 0, 0, 0,  10,   6, 5, 0},
      '{0, 1, 1, 0, 1, 1,  10,   6, 3, 0},
      '{0, 1, 1, 1, 0, 2,   4, 300, 1, 0},
      '{3, 1, 1, 0, 0, 0,   0,   4, 2, 0}
   };

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic p, input logic x);
      @(negedge clk);
      n_sim += int'(mod_clk_en);
      n_o1  += int'(clk1_en);
      n_o2  += int'(clk2_en);
      pll_tick  = p;
      xtal_tick = x;
   endtask

   task automatic tick_pll(input int n);
      for (int i = 0; i < n; i++) begin step(1'b1, 1'b0); step(1'b0, 1'b0); end
   endtask

   task automatic tick_xtal(input int n);
      for (int i = 0; i < n; i++) begin step(1'b0, 1'b1); step(1'b0, 1'b0); end
   endtask

   task automatic clear_counts();
      n_sim = 0; n_o1 = 0; n_o2 = 0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; stop_req = 1'b0; wake = 1'b0;
      step(1'b0, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
      rst_n = 1'b1;
      step(1'b0, 1'b0);
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      rst_n = 1'b0;
      step(1'b0, 1'b0); step(1'b1, 1'b1); step(1'b0, 1'b0);
      check("R1 mod_clk_en in reset", int'(mod_clk_en), 0);
      check("R1 clk2_en in reset", int'(clk2_en), 0);
      check("R1 oe in reset", int'(clk1_oe) + int'(clk2_oe), 0);

      // vector table: R2 R3 R4 R6 R7 R9
      foreach (VECS[k]) begin
         do_reset();
         cfg_slowgo       = 3'(VECS[k].code);
         cfg_stop_pll_off = VECS[k].off[0];
         cfg_div128       = VECS[k].d128[0];
         drv1             = 2'(VECS[k].d1);
         drv2             = 2'(VECS[k].d2);
         step(1'b0, 1'b0);
         if (VECS[k].stop != 0) begin
            stop_req = 1'b1;
            step(1'b0, 1'b0);
            stop_req = 1'b0;
            tick_pll(2 << VECS[k].code);
         end
         step(1'b0, 1'b0);
         clear_counts();
         tick_pll(VECS[k].npll);
         tick_xtal(VECS[k].nx);
         step(1'b0, 1'b0);
         check($sformatf("R2/R6/R7 vec%0d module strobes", k), n_sim, VECS[k].esim);
         check($sformatf("R3 vec%0d out1 strobes", k), n_o1,
               (VECS[k].d1 == 3) ? 0 : VECS[k].esim);
         check($sformatf("R4 vec%0d out2 strobes", k), n_o2,
               (VECS[k].d2 == 3) ? 0 : VECS[k].eo2);
         check($sformatf("R9 vec%0d clk1_oe", k), int'(clk1_oe), (VECS[k].d1 == 3) ? 0 : 1);
         check($sformatf("R9 vec%0d clk2_oe", k), int'(clk2_oe), (VECS[k].d2 == 3) ? 0 : 1);
      end

      // R2: strobe lands one cycle after the completing tick, single cycle wide
      do_reset();
      cfg_slowgo = 3'd0; cfg_stop_pll_off = 1'b0; cfg_div128 = 1'b0; drv1 = 2'b00; drv2 = 2'b00;
      step(1'b1, 1'b0); step(1'b0, 1'b0);
      check("R2 no strobe after first tick", int'(mod_clk_en), 0);
      step(1'b1, 1'b0);
      check("R2 no strobe before second tick", int'(mod_clk_en), 0);
      step(1'b0, 1'b0);
      check("R2 strobe after second tick", int'(mod_clk_en), 1);
      step(1'b0, 1'b0);
      check("R2 strobe one cycle wide", int'(mod_clk_en), 0);

      // R5 R10: stop request mid-period waits for the boundary
      do_reset();
      cfg_slowgo = 3'd1; cfg_stop_pll_off = 1'b1; cfg_div128 = 1'b0;
      tick_pll(1);
      stop_req = 1'b1; step(1'b0, 1'b0); stop_req = 1'b0;
      clear_counts();
      tick_pll(2);
      tick_xtal(2);
      step(1'b0, 1'b0);
      check("R5 still running before boundary", n_sim, 0);
      tick_pll(1);
      step(1'b0, 1'b0);
      check("R5 boundary strobe", n_sim, 1);
      clear_counts();
      tick_xtal(1);
      step(1'b0, 1'b0);
      check("R10 first stop period full length", n_sim, 0);
      tick_xtal(1);
      tick_pll(4);
      step(1'b0, 1'b0);
      check("R7 crystal source after entry", n_sim, 1);

      // R8: wake returns at next crystal boundary
      do_reset();
      cfg_slowgo = 3'd0; cfg_stop_pll_off = 1'b1; cfg_div128 = 1'b0;
      stop_req = 1'b1; step(1'b0, 1'b0); stop_req = 1'b0;
      tick_pll(2);
      wake = 1'b1; step(1'b0, 1'b0); wake = 1'b0;
      clear_counts();
      tick_pll(4);
      step(1'b0, 1'b0);
      check("R8 waits for stop-source boundary", n_sim, 0);
      tick_xtal(2);
      step(1'b0, 1'b0);
      check("R8 exit boundary strobe", n_sim, 1);
      clear_counts();
      tick_pll(4);
      step(1'b0, 1'b0);
      check("R8 running after wake (module)", n_sim, 2);
      check("R8 running after wake (out2)", n_o2, 4);

      // R8: wake and stop together -> stays running
      do_reset();
      cfg_slowgo = 3'd0; cfg_stop_pll_off = 1'b0;
      stop_req = 1'b1; wake = 1'b1; step(1'b0, 1'b0);
      stop_req = 1'b0; wake = 1'b0;
      clear_counts();
      tick_pll(4);
      step(1'b0, 1'b0);
      check("R8 simultaneous wake wins", n_o2, 4);

      // R9: live drive code change
      drv1 = 2'b11; step(1'b0, 1'b0); step(1'b0, 1'b0);
      check("R9 oe drops for code 11", int'(clk1_oe), 0);
      drv1 = 2'b10; step(1'b0, 1'b0); step(1'b0, 1'b0);
      check("R9 oe returns for code 10", int'(clk1_oe), 1);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule